// File: doc/BRIEF.md
# UART Receive Buffer with Per-Character Error Tags

This block is the store that sits between a UART's receive deserializer and the host. Each time the deserializer reports a completed character, the block stores the byte together with three status bits: break, parity error and framing error. The stored item moves through the buffer as one 11-bit entry. The host reads entries in arrival order through a show-ahead read port. An empty flag and a full flag describe the buffer's state.

An overrun indicator is kept apart from the stored entries. It sets when a character completes and there is no room for it. That character is dropped. The indicator stays set until the host clears it.

A mode input turns the buffer into a single-entry holding register. The storage is not bypassed in this mode. Only entry zero is used, and the flags report full after one character. Any change of mode empties the buffer.

A loopback control picks which signal feeds the deserializer's serial input. It can be the external receive pin or the block's own transmit serial output.

Top module: `uart_rx_errfifo`

## Requirements
- R1: `rd_data_o` shows the oldest stored entry while `empty_o` is low. Its bits [7:0] hold the byte, bit 8 the framing error, bit 9 the parity error and bit 10 the break flag. All four fields come back as written, in arrival order.
- R2: In buffer mode (`hold_mode_i` = 0), up to DEPTH entries are held. `full_o` rises when DEPTH entries are stored and `empty_o` rises when none are.
- R3: A `char_done_i` pulse while `full_o` is high and no read is accepted in that cycle sets `overrun_o` on the next clock. The character is discarded and the stored entries are unchanged.
- R4: When the buffer is full, a read and a new character in the same cycle are both accepted. `overrun_o` does not rise and `full_o` stays high.
- R5: `overrun_o` stays high until an `ovr_clr_i` pulse clears it. If a clear and a new overrun fall in the same cycle, the flag stays set.
- R6: In holding mode (`hold_mode_i` = 1), `full_o` rises after one character. A second character before that one is read sets `overrun_o`, and the first character is kept.
- R7: Any change of `hold_mode_i` flushes the buffer. `empty_o` is high on the next clock, and a character or read in the switching cycle is discarded.
- R8: `rx_serial_o` follows `tx_serial_i` while `loopback_en_i` is 1, and follows `rx_pad_i` while it is 0.
- R9: A read request while the buffer is empty is ignored. The next character stored is the next one read.
- R10: After reset, `empty_o` = 1, `full_o` = 0 and `overrun_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_mode_i | input | 1 | 1 selects single-entry holding mode, 0 selects buffer mode |
| loopback_en_i | input | 1 | 1 routes the transmit serial output to the receive serial path |
| tx_serial_i | input | 1 | Transmit serial line from the UART transmitter |
| rx_pad_i | input | 1 | External receive serial pin |
| rx_serial_o | output | 1 | Serial input to the receive deserializer |
| char_done_i | input | 1 | One-cycle strobe: a character has completed |
| char_data_i | input | 8 | Received byte |
| brk_err_i | input | 1 | Break detected on this character |
| par_err_i | input | 1 | Parity error on this character |
| frm_err_i | input | 1 | Framing error on this character |
| rd_en_i | input | 1 | Host read: removes the entry shown on `rd_data_o` |
| rd_data_o | output | 11 | Oldest entry: {break, parity, framing, byte} |
| empty_o | output | 1 | No entry stored |
| full_o | output | 1 | Capacity of the current mode reached |
| overrun_o | output | 1 | Sticky overrun indicator |
| ovr_clr_i | input | 1 | Clears the overrun indicator |

## Verification
The bench fills the buffer to the brim and then offers one more character. A design that pushed it anyway would corrupt the oldest entry or wrap the count, and the drain would return the wrong sequence. A read and a character at once when full must not be mistaken for overrun. A clear that meets a fresh overrun must lose to it, or overruns would go unseen. Holding mode is checked for a full flag after one entry and for keeping the first character rather than the newer one. A mode switch with data inside must leave the buffer empty, since stale pointers would show old bytes. Reads of an empty buffer must not move the read pointer, or later data would come out shifted.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   localparam int BYTE_W = 8;

   // bit 10 break, bit 9 parity, bit 8 framing, bits 7:0 byte
   typedef struct packed {
      logic              brk;
      logic              par;
      logic              frm;
      logic [BYTE_W-1:0] data;
   } rxq_entry_t;

   localparam int ENTRY_W = $bits(rxq_entry_t);

endpackage

// File: rtl/uart_rxq_loop.sv
module uart_rxq_loop #(
   parameter bit LOOP_PRESENT = 1'b1
) (
   input  logic lb_en_i,
   input  logic tx_i,
   input  logic pad_i,
   output logic rx_o
);

   generate
      if (LOOP_PRESENT) begin : g_mux
         assign rx_o = lb_en_i ? tx_i : pad_i;
      end else begin : g_direct
         logic unused_lb;
         assign unused_lb = lb_en_i ^ tx_i;
         assign rx_o      = pad_i;
      end
   endgenerate

endmodule

// File: rtl/uart_rxq_mem.sv
module uart_rxq_mem #(
   parameter int DEPTH  = 16,
   parameter int WIDTH  = 11,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [WIDTH-1:0]  wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [WIDTH-1:0]  rd_data_o
);

   logic [WIDTH-1:0] slot [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot[i] <= '0;
            end else if (wr_en_i && (wr_addr_i == ADDR_W'(i))) begin
               slot[i] <= wr_data_i;
            end
         end
      end
   endgenerate

   assign rd_data_o = slot[rd_addr_i];

endmodule

// File: rtl/uart_rxq_ctrl.sv
module uart_rxq_ctrl #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = $clog2(DEPTH),
   parameter int CNT_W  = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_mode_i,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              ovr_clr_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              overrun_o,
   output logic              mode_q_o
);

   logic [ADDR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count, cap;
   logic              mode_q, flush, pop_ok, push_ok, ovr_hit, ovr_q;

   // capacity follows the registered mode so flags match stored state
   assign cap     = mode_q ? CNT_W'(1) : CNT_W'(DEPTH);
   assign empty_o = (count == '0);
   assign full_o  = (count == cap);
   assign flush   = (hold_mode_i != mode_q);

   assign pop_ok  = pop_i && !empty_o && !flush;
   assign push_ok = push_i && !flush && (!full_o || pop_ok);
   assign ovr_hit = push_i && !flush && full_o && !pop_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovr_q  <= 1'b0;
      end else begin
         mode_q <= hold_mode_i;
         ovr_q  <= ovr_hit | (ovr_q & ~ovr_clr_i);
         if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
         end else begin
            // holding mode pins both pointers to the bottom slot
            if (push_ok && !mode_q) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok && !mode_q)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
               2'b10:   count <= count + 1'b1;
               2'b01:   count <= count - 1'b1;
               default: count <= count;
            endcase
         end
      end
   end

   assign wr_en_o   = push_ok;
   assign wr_addr_o = wr_ptr;
   assign rd_addr_o = rd_ptr;
   assign overrun_o = ovr_q;
   assign mode_q_o  = mode_q;

endmodule

// File: rtl/uart_rx_errfifo.sv
module uart_rx_errfifo
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter bit LOOP_PRESENT = 1'b1,
   localparam int ADDR_W      = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold_mode_i,
   input  logic               loopback_en_i,
   input  logic               tx_serial_i,
   input  logic               rx_pad_i,
   output logic               rx_serial_o,
   input  logic               char_done_i,
   input  logic [BYTE_W-1:0]  char_data_i,
   input  logic               brk_err_i,
   input  logic               par_err_i,
   input  logic               frm_err_i,
   input  logic               rd_en_i,
   output logic [ENTRY_W-1:0] rd_data_o,
   output logic               empty_o,
   output logic               full_o,
   output logic               overrun_o,
   input  logic               ovr_clr_i
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_rx_errfifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   rxq_entry_t        wr_entry;
   logic              wr_en, mode_q;
   logic [ADDR_W-1:0] wr_addr, rd_addr;

   assign wr_entry = '{brk: brk_err_i, par: par_err_i, frm: frm_err_i,
                       data: char_data_i};

   uart_rxq_loop #(.LOOP_PRESENT(LOOP_PRESENT)) i_loop (
      .lb_en_i (loopback_en_i),
      .tx_i    (tx_serial_i),
      .pad_i   (rx_pad_i),
      .rx_o    (rx_serial_o)
   );

   uart_rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .hold_mode_i (hold_mode_i),
      .push_i      (char_done_i),
      .pop_i       (rd_en_i),
      .ovr_clr_i   (ovr_clr_i),
      .wr_en_o     (wr_en),
      .wr_addr_o   (wr_addr),
      .rd_addr_o   (rd_addr),
      .empty_o     (empty_o),
      .full_o      (full_o),
      .overrun_o   (overrun_o),
      .mode_q_o    (mode_q)
   );

   uart_rxq_mem #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) i_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_entry),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_data_o)
   );

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk (
   input logic clk,
   input logic rst_n,
   input logic hold_mode_i,
   input logic mode_q,
   input logic char_done_i,
   input logic rd_en_i,
   input logic ovr_clr_i,
   input logic empty_o,
   input logic full_o,
   input logic overrun_o
);

   a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty_o && full_o));

   a_r3_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && char_done_i && !rd_en_i && (hold_mode_i == mode_q)) |=> overrun_o);

   a_r4_read_write_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && char_done_i && rd_en_i && !overrun_o && !ovr_clr_i
       && (hold_mode_i == mode_q)) |=> (full_o && !overrun_o));

   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && !ovr_clr_i) |=> overrun_o);

   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_clr_i && !char_done_i) |=> !overrun_o);

   a_r6_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && hold_mode_i && !empty_o) |-> full_o);

   a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_mode_i != mode_q) |=> empty_o);

endmodule

bind uart_rx_errfifo uart_rxq_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hold_mode_i (hold_mode_i),
   .mode_q      (mode_q),
   .char_done_i (char_done_i),
   .rd_en_i     (rd_en_i),
   .ovr_clr_i   (ovr_clr_i),
   .empty_o     (empty_o),
   .full_o      (full_o),
   .overrun_o   (overrun_o)
);

// File: tb/test_uart_rx_errfifo.sv
module test_uart_rx_errfifo;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold_mode_i = 1'b0, loopback_en_i = 1'b0;
   logic        tx_serial_i = 1'b0, rx_pad_i = 1'b0, rx_serial_o;
   logic        char_done_i = 1'b0;
   logic [7:0]  char_data_i = '0;
   logic        brk_err_i = 1'b0, par_err_i = 1'b0, frm_err_i = 1'b0;
   logic        rd_en_i = 1'b0, ovr_clr_i = 1'b0;
   logic [10:0] rd_data_o;
   logic        empty_o, full_o, overrun_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [10:0] sb[$];
   int          cap = DEPTH;
   bit          exp_ovr = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_errfifo #(.DEPTH(DEPTH)) i_uart_rx_errfifo (
      .clk(clk), .rst_n(rst_n), .hold_mode_i(hold_mode_i),
      .loopback_en_i(loopback_en_i), .tx_serial_i(tx_serial_i),
      .rx_pad_i(rx_pad_i), .rx_serial_o(rx_serial_o),
      .char_done_i(char_done_i), .char_data_i(char_data_i),
      .brk_err_i(brk_err_i), .par_err_i(par_err_i), .frm_err_i(frm_err_i),
      .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .empty_o(empty_o),
      .full_o(full_o), .overrun_o(overrun_o), .ovr_clr_i(ovr_clr_i)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_flags(input string req);
      check(empty_o == (sb.size() == 0), {req, " empty_o"}, 32'(empty_o), 32'(sb.size() == 0));
      check(full_o == (sb.size() == cap), {req, " full_o"}, 32'(full_o), 32'(sb.size() == cap));
      check(overrun_o == exp_ovr, {req, " overrun_o"}, 32'(overrun_o), 32'(exp_ovr));
   endtask

   // one clock: flags checked, then inputs driven, scoreboard updated
   task automatic cyc(input bit push, input logic [10:0] ent, input bit rd,
                      input bit clr, input string req);
      bit rd_ok, push_ok, ovr_set, was_full;
      @(negedge clk);
      check_flags(req);
      char_done_i = push;
      {brk_err_i, par_err_i, frm_err_i, char_data_i} = ent;
      rd_en_i     = rd;
      ovr_clr_i   = clr;
      rd_ok    = rd && (sb.size() > 0);
      was_full = (sb.size() == cap);
      push_ok  = push && (!was_full || rd_ok);
      ovr_set  = push && was_full && !rd_ok;
      if (rd_ok) begin
         #1;
         check(rd_data_o == sb[0], {req, " rd_data_o"}, 32'(rd_data_o), 32'(sb[0]));
      end
      @(posedge clk);
      if (rd_ok)   void'(sb.pop_front());
      if (push_ok) sb.push_back(ent);
      exp_ovr = ovr_set | (exp_ovr & ~clr);
      #1;
      char_done_i = 1'b0; rd_en_i = 1'b0; ovr_clr_i = 1'b0;
   endtask

   task automatic set_mode(input bit hold);
      @(negedge clk);
      hold_mode_i = hold;
      @(posedge clk);
      #1;
      sb.delete();
      cap = hold ? 1 : DEPTH;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10: reset state
      check(empty_o == 1'b1, "R10 empty_o", 32'(empty_o), 1);
      check(full_o == 1'b0, "R10 full_o", 32'(full_o), 0);
      check(overrun_o == 1'b0, "R10 overrun_o", 32'(overrun_o), 0);
      rst_n = 1'b1;

      // R1: field layout, arrival order, various error tags
      cyc(1, {3'b100, 8'hA5}, 0, 0, "R1");
      cyc(1, {3'b010, 8'h3C}, 0, 0, "R1");
      cyc(1, {3'b001, 8'hFF}, 0, 0, "R1");
      cyc(1, {3'b111, 8'h00}, 0, 0, "R1");
      for (int i = 0; i < 4; i++) cyc(0, '0, 1, 0, "R1");

      // R2: fill to DEPTH
      for (int i = 0; i < DEPTH; i++)
         cyc(1, {3'(i), 8'(8'h40 + i)}, 0, 0, "R2");
      // R3: character while full is dropped, overrun sets
      cyc(1, {3'b111, 8'hEE}, 0, 0, "R3");
      cyc(0, '0, 0, 0, "R3");
      // R5: sticky, then clear racing a new overrun
      cyc(0, '0, 0, 0, "R5");
      cyc(1, {3'b000, 8'hDD}, 0, 1, "R5");
      cyc(0, '0, 0, 1, "R5");
      cyc(0, '0, 0, 0, "R5");
      // R4: read and write together while full
      cyc(1, {3'b101, 8'h77}, 1, 0, "R4");
      cyc(0, '0, 0, 0, "R4");
      // drain and confirm stored contents (R3 unchanged data)
      for (int i = 0; i < DEPTH; i++) cyc(0, '0, 1, 0, "R3");
      // R9: reads on empty ignored
      cyc(0, '0, 1, 0, "R9");
      cyc(0, '0, 1, 0, "R9");
      cyc(1, {3'b010, 8'h5A}, 0, 0, "R9");
      cyc(1, {3'b000, 8'h11}, 0, 0, "R9");

      // R7: mode change flushes stored data
      set_mode(1'b1);
      cyc(0, '0, 0, 0, "R7");
      // R6: one-entry holding register
      cyc(1, {3'b001, 8'hC3}, 0, 0, "R6");
      cyc(1, {3'b100, 8'h99}, 0, 0, "R6");
      cyc(0, '0, 0, 1, "R6");
      cyc(1, {3'b110, 8'h42}, 1, 0, "R6");
      cyc(0, '0, 1, 0, "R6");
      cyc(1, {3'b011, 8'h24}, 0, 0, "R7");
      set_mode(1'b0);
      cyc(0, '0, 0, 0, "R7");
      cyc(1, {3'b000, 8'h81}, 0, 0, "R7");
      cyc(0, '0, 1, 0, "R7");
      cyc(0, '0, 0, 0, "R7");

      // R8: loopback path selection
      @(negedge clk);
      loopback_en_i = 1'b1; tx_serial_i = 1'b1; rx_pad_i = 1'b0;
      #1 check(rx_serial_o == 1'b1, "R8 loopback tx", 32'(rx_serial_o), 1);
      tx_serial_i = 1'b0; rx_pad_i = 1'b1;
      #1 check(rx_serial_o == 1'b0, "R8 loopback tx", 32'(rx_serial_o), 0);
      loopback_en_i = 1'b0;
      #1 check(rx_serial_o == 1'b1, "R8 pad path", 32'(rx_serial_o), 1);
      rx_pad_i = 1'b0;
      #1 check(rx_serial_o == 1'b0, "R8 pad path", 32'(rx_serial_o), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule